// File: doc/BRIEF.md
# Guarded Byte Load Unit

This block is the load stage for one unsigned byte load. In the issue cycle it takes a 32-bit address operand, an optional guard bit, the issue slot index and a destination register index. It sends a word-aligned read request to a data memory whose word comes back two cycles later. It selects the addressed byte from that word, zero-extends the byte to 32 bits and presents it on a register-file write port exactly three cycles after issue.

The guard controls the whole operation. With the guard cleared, the unit issues no memory request, performs no writeback and asserts no cache-status strobe. When no guard is supplied, the operation always runs. The unit accepts the operation only in issue slots 4 and 5 and flags any other slot.

An address inside the memory-mapped I/O aperture gives an undefined result, so the unit raises a flag next to the writeback for such an access. There is no byte-order input, because only a single byte is read.

Top module: `byte_load_unit`

## Requirements
- R1: The written value is the byte selected by address bits [1:0] from the returned word (lane k = bits 8k+7..8k), zero-extended to 32 bits. For example, byte 0x84 is written as 0x00000084.
- R2: An enabled operation drives `mem_req` high in its issue cycle with `mem_addr` = {src_addr[31:2], 2'b00}. It consumes `mem_rdata` two cycles later and asserts `wb_en` exactly three cycles after the issue cycle.
- R3: When `guard_present` is 0, the operation is enabled regardless of `guard_lsb`. When `guard_present` is 1, only `guard_lsb` decides.
- R4: With `guard_present`=1 and `guard_lsb`=0, the operation causes no `mem_req`, no `wb_en` and no `cache_upd`.
- R5: `cache_upd` pulses in the writeback cycle of an enabled operation whose `cacheable` input was 1 and whose address is outside the I/O aperture. Otherwise it stays low.
- R6: An address whose bits [31:21] equal those of 0xEFE00000 lies in the I/O aperture. Such an access raises `mmio_flag` in its writeback cycle.
- R7: A valid issue in a slot other than 4 or 5 raises `illegal_slot` in the same cycle and is dropped: no `mem_req` and no writeback.
- R8: `wb_idx` returns the destination index of the matching operation. Operations issued in consecutive cycles write back in consecutive cycles, in issue order.
- R9: While `rst` is high, and in the cycle after it falls, `wb_en`, `cache_upd` and `mmio_flag` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | An operation is presented this cycle |
| issue_slot | input | 3 | Issue slot index of the operation |
| src_addr | input | 32 | Byte address operand |
| guard_present | input | 1 | A guard accompanies the operation |
| guard_lsb | input | 1 | Least significant bit of the guard value |
| dest_idx | input | 7 | Destination register index |
| cacheable | input | 1 | The address is cacheable |
| mem_req | output | 1 | Read request to data memory |
| mem_addr | output | 32 | Word-aligned read address |
| mem_rdata | input | 32 | Read word, valid two cycles after the request |
| illegal_slot | output | 1 | Operation presented in a slot that is not allowed |
| wb_en | output | 1 | Destination register write enable |
| wb_idx | output | 7 | Destination register index for the write |
| wb_data | output | 32 | Zero-extended byte result |
| cache_upd | output | 1 | Permission to update cache status bits |
| mmio_flag | output | 1 | The writeback comes from an I/O-aperture access |

## Verification
A new issue and the writeback of an older operation can land in the same cycle. In that cycle the unit both evaluates the guard and slot of the incoming operation, driving `mem_req` or `illegal_slot`, and delivers the retiring result with its strobes. The bench provokes this with unbroken streams of back-to-back issues that mix guard-off, bad-slot, I/O-aperture and cacheable operations. It checks the issue-side outputs a moment after driving the inputs. A scoreboard stamped with the issue cycle judges every writeback by its cycle, index, data and strobes. A missing, extra or early result is therefore reported even while new operations keep arriving.

// File: rtl/blu_pkg.sv
package blu_pkg;

    parameter int ADDR_W  = 32;
    parameter int DATA_W  = 32;
    parameter int IDX_W   = 7;
    parameter int SLOT_W  = 3;
    parameter int SLOT_LO = 4;
    parameter int SLOT_HI = 5;

    typedef struct packed {
        logic             valid;
        logic             side_fx;
        logic             mmio;
        logic [1:0]       lane;
        logic [IDX_W-1:0] dest;
    } blu_stage_t;

    function automatic logic slot_legal(input logic [SLOT_W-1:0] slot);
        return (int'(slot) == SLOT_LO) || (int'(slot) == SLOT_HI);
    endfunction

    function automatic logic [7:0] pick_lane(input logic [DATA_W-1:0] word,
                                             input logic [1:0] lane);
        return word[{lane, 3'b000} +: 8];
    endfunction

    function automatic logic [DATA_W-1:0] zext_byte(input logic [7:0] b);
        return {{(DATA_W-8){1'b0}}, b};
    endfunction

endpackage

// File: rtl/blu_issue.sv
module blu_issue
    import blu_pkg::*;
#(
    parameter logic [ADDR_W-1:0] MMIO_BASE = 32'hEFE0_0000,
    parameter int                MMIO_BITS = 21
) (
    input  logic              issue_valid,
    input  logic [SLOT_W-1:0] issue_slot,
    input  logic [ADDR_W-1:0] src_addr,
    input  logic              guard_present,
    input  logic              guard_lsb,
    input  logic [IDX_W-1:0]  dest_idx,
    input  logic              cacheable,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              illegal_slot,
    output blu_stage_t        entry
);
    localparam int TAG_W = ADDR_W - MMIO_BITS;

    logic slot_ok;
    logic guard_on;
    logic in_aperture;
    logic enabled;

    always_comb begin
        slot_ok     = slot_legal(issue_slot);
        guard_on    = !guard_present || guard_lsb;
        in_aperture = (src_addr[ADDR_W-1 -: TAG_W] == MMIO_BASE[ADDR_W-1 -: TAG_W]);
        enabled     = issue_valid && slot_ok && guard_on;

        illegal_slot = issue_valid && !slot_ok;
        mem_req      = enabled;
        mem_addr     = {src_addr[ADDR_W-1:2], 2'b00};

        entry.valid   = enabled;
        entry.side_fx = cacheable && !in_aperture;
        entry.mmio    = in_aperture;
        entry.lane    = src_addr[1:0];
        entry.dest    = dest_idx;
    end
endmodule

// File: rtl/blu_pipe.sv
module blu_pipe
    import blu_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  blu_stage_t stage_in,
    output blu_stage_t stage_out
);
    blu_stage_t st [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        if (i == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst) st[0] <= '0;
                else     st[0] <= stage_in;
            end
            // R2
            head_capture_chk: assert property (@(posedge clk) disable iff (rst)
                stage_in.valid |=> st[0].valid);
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (rst) st[i] <= '0;
                else     st[i] <= st[i-1];
            end
            // R2
            body_advance_chk: assert property (@(posedge clk) disable iff (rst)
                st[i].valid |-> $past(st[i-1].valid));
        end
    end

    assign stage_out = st[DEPTH-1];
endmodule

// File: rtl/blu_extract.sv
module blu_extract
    import blu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  blu_stage_t        stage_in,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              wb_en,
    output logic [IDX_W-1:0]  wb_idx,
    output logic [DATA_W-1:0] wb_data,
    output logic              cache_upd,
    output logic              mmio_flag
);
    always_ff @(posedge clk) begin
        if (rst) begin
            wb_en     <= 1'b0;
            wb_idx    <= '0;
            wb_data   <= '0;
            cache_upd <= 1'b0;
            mmio_flag <= 1'b0;
        end else begin
            wb_en     <= stage_in.valid;
            wb_idx    <= stage_in.dest;
            wb_data   <= zext_byte(pick_lane(mem_rdata, stage_in.lane));
            cache_upd <= stage_in.valid && stage_in.side_fx;
            mmio_flag <= stage_in.valid && stage_in.mmio;
        end
    end

    // R2
    wb_from_stage_chk: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> $past(stage_in.valid));
    // R5
    side_fx_needs_wb_chk: assert property (@(posedge clk) disable iff (rst)
        cache_upd |-> (wb_en && !mmio_flag));
    // R6
    mmio_needs_wb_chk: assert property (@(posedge clk) disable iff (rst)
        mmio_flag |-> wb_en);
endmodule

// File: rtl/byte_load_unit.sv
module byte_load_unit
    import blu_pkg::*;
#(
    parameter int                LATENCY   = 3,
    parameter logic [ADDR_W-1:0] MMIO_BASE = 32'hEFE0_0000,
    parameter int                MMIO_BITS = 21
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              issue_valid,
    input  logic [SLOT_W-1:0] issue_slot,
    input  logic [ADDR_W-1:0] src_addr,
    input  logic              guard_present,
    input  logic              guard_lsb,
    input  logic [IDX_W-1:0]  dest_idx,
    input  logic              cacheable,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              illegal_slot,
    output logic              wb_en,
    output logic [IDX_W-1:0]  wb_idx,
    output logic [DATA_W-1:0] wb_data,
    output logic              cache_upd,
    output logic              mmio_flag
);
    localparam int MEM_LAT = LATENCY - 1;

    blu_stage_t entry;
    blu_stage_t aligned;

    blu_issue #(
        .MMIO_BASE (MMIO_BASE),
        .MMIO_BITS (MMIO_BITS)
    ) u_issue (
        .issue_valid   (issue_valid),
        .issue_slot    (issue_slot),
        .src_addr      (src_addr),
        .guard_present (guard_present),
        .guard_lsb     (guard_lsb),
        .dest_idx      (dest_idx),
        .cacheable     (cacheable),
        .mem_req       (mem_req),
        .mem_addr      (mem_addr),
        .illegal_slot  (illegal_slot),
        .entry         (entry)
    );

    blu_pipe #(.DEPTH(MEM_LAT)) u_pipe (
        .clk       (clk),
        .rst       (rst),
        .stage_in  (entry),
        .stage_out (aligned)
    );

    blu_extract u_extract (
        .clk       (clk),
        .rst       (rst),
        .stage_in  (aligned),
        .mem_rdata (mem_rdata),
        .wb_en     (wb_en),
        .wb_idx    (wb_idx),
        .wb_data   (wb_data),
        .cache_upd (cache_upd),
        .mmio_flag (mmio_flag)
    );

    // R4
    guard_off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && guard_present && !guard_lsb) |-> !mem_req);
    // R7
    bad_slot_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        illegal_slot |-> !mem_req);
    // R9
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (!wb_en && !cache_upd && !mmio_flag));
endmodule

// File: tb/byte_load_unit_tb.sv
module byte_load_unit_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        issue_valid;
    logic [2:0]  issue_slot;
    logic [31:0] src_addr;
    logic        guard_present;
    logic        guard_lsb;
    logic [6:0]  dest_idx;
    logic        cacheable;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic [31:0] mem_rdata;
    logic        illegal_slot;
    logic        wb_en;
    logic [6:0]  wb_idx;
    logic [31:0] wb_data;
    logic        cache_upd;
    logic        mmio_flag;

    always #10 clk = ~clk;

    byte_load_unit u_dut (
        .clk(clk), .rst(rst), .issue_valid(issue_valid), .issue_slot(issue_slot),
        .src_addr(src_addr), .guard_present(guard_present), .guard_lsb(guard_lsb),
        .dest_idx(dest_idx), .cacheable(cacheable), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .illegal_slot(illegal_slot),
        .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data),
        .cache_upd(cache_upd), .mmio_flag(mmio_flag)
    );

    function automatic logic [7:0] byte_at(input logic [31:0] a);
        case (a)
            32'h0000_0d00: return 8'h22;
            32'h0000_0d01: return 8'h33;
            32'h0000_0d04: return 8'h84;
            default:       return a[7:0] ^ a[15:8] ^ 8'hA5;
        endcase
    endfunction

    function automatic logic [31:0] word_at(input logic [31:0] wa);
        return {byte_at(wa + 3), byte_at(wa + 2), byte_at(wa + 1), byte_at(wa)};
    endfunction

    // two-cycle data memory
    logic [31:0] addr_q;
    always @(posedge clk) begin
        addr_q    <= mem_addr;
        mem_rdata <= word_at(addr_q);
    end

    int cnt = 0;
    always @(posedge clk) cnt <= cnt + 1;

    typedef struct {
        int          cyc;
        logic [6:0]  idx;
        logic [31:0] data;
        logic        cu;
        logic        mm;
    } exp_t;
    exp_t q[$];

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic issue_op(input logic [2:0] slot, input logic [31:0] addr,
                            input logic gp, input logic gl, input logic [6:0] dst,
                            input logic cach);
        bit   legal, en, mm;
        exp_t e;
        @(negedge clk);
        issue_valid   = 1'b1;
        issue_slot    = slot;
        src_addr      = addr;
        guard_present = gp;
        guard_lsb     = gl;
        dest_idx      = dst;
        cacheable     = cach;
        #1;
        legal = (slot == 3'd4) || (slot == 3'd5);
        en    = legal && (!gp || gl);
        mm    = (addr[31:21] == 11'h77F);
        chk(illegal_slot == !legal, "R7 illegal_slot", 32'(illegal_slot), 32'(!legal));
        chk(mem_req == en, "R3/R4 mem_req", 32'(mem_req), 32'(en));
        if (en) begin
            chk(mem_addr == {addr[31:2], 2'b00}, "R2 mem_addr", mem_addr, {addr[31:2], 2'b00});
            e.cyc  = cnt;
            e.idx  = dst;
            e.data = {24'h0, byte_at(addr)};
            e.cu   = cach && !mm;
            e.mm   = mm;
            q.push_back(e);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        issue_valid = 1'b0;
    endtask

    // monitor / scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (!rst) begin
                while (q.size() > 0 && cnt > q[0].cyc + 3) begin
                    chk(1'b0, "R2 missing writeback", 32'(cnt), 32'(q[0].cyc + 3));
                    void'(q.pop_front());
                end
                if (wb_en) begin
                    if (q.size() == 0) begin
                        chk(1'b0, "R4 unexpected writeback", {25'h0, wb_idx}, 32'h0);
                    end else begin
                        exp_t e;
                        e = q.pop_front();
                        chk(cnt == e.cyc + 3, "R2 latency", 32'(cnt), 32'(e.cyc + 3));
                        chk(wb_idx == e.idx, "R8 wb_idx", {25'h0, wb_idx}, {25'h0, e.idx});
                        chk(wb_data == e.data, "R1 wb_data", wb_data, e.data);
                        chk(cache_upd == e.cu, "R5 cache_upd", 32'(cache_upd), 32'(e.cu));
                        chk(mmio_flag == e.mm, "R6 mmio_flag", 32'(mmio_flag), 32'(e.mm));
                    end
                end else begin
                    chk(!cache_upd && !mmio_flag, "R4/R5 strobe without writeback",
                        {30'h0, cache_upd, mmio_flag}, 32'h0);
                end
            end
        end
    end

    initial begin
        rst = 1'b1;
        issue_valid = 1'b0; issue_slot = '0; src_addr = '0;
        guard_present = 1'b0; guard_lsb = 1'b0; dest_idx = '0; cacheable = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!wb_en && !cache_upd && !mmio_flag, "R9 reset state",
            {29'h0, wb_en, cache_upd, mmio_flag}, 32'h0);
        chk(!mem_req && !illegal_slot, "R9 idle issue outputs",
            {30'h0, mem_req, illegal_slot}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        chk(!wb_en, "R9 after reset", 32'(wb_en), 32'h0);

        // example-style loads, back to back
        issue_op(3'd4, 32'h0000_0d00, 1'b0, 1'b0, 7'd60, 1'b1); // R3 no guard -> enabled
        issue_op(3'd5, 32'h0000_0d04, 1'b1, 1'b0, 7'd70, 1'b1); // R4 guard off
        issue_op(3'd5, 32'h0000_0d04, 1'b1, 1'b1, 7'd80, 1'b1); // R1 0x84 zero-extended
        issue_op(3'd4, 32'h0000_0d01, 1'b0, 1'b1, 7'd90, 1'b0); // R5 not cacheable
        idle();
        repeat (5) @(negedge clk);

        // every lane, consecutive cycles (R1, R8)
        for (int i = 0; i < 4; i++)
            issue_op(3'd4 + 3'(i % 2), 32'h0000_1230 + 32'(i), 1'b1, 1'b1, 7'(10 + i), 1'(i % 2));
        idle();
        repeat (5) @(negedge clk);

        // bad slots interleaved with good ones (R7)
        for (int s = 0; s < 8; s++)
            issue_op(3'(s), 32'h0000_2000 + 32'(s * 5), 1'b0, 1'b0, 7'(20 + s), 1'b1);
        idle();
        repeat (5) @(negedge clk);

        // I/O aperture (R6) and edge just outside it
        issue_op(3'd4, 32'hEFE0_0013, 1'b1, 1'b1, 7'd33, 1'b1);
        issue_op(3'd5, 32'hEFFF_FFFE, 1'b0, 1'b0, 7'd34, 1'b1);
        issue_op(3'd4, 32'hEFDF_FFFF, 1'b0, 1'b0, 7'd35, 1'b1);
        issue_op(3'd5, 32'hEFE0_0001, 1'b1, 1'b0, 7'd36, 1'b1);
        idle();
        repeat (5) @(negedge clk);

        // mixed stream: issues overlap writebacks (R2, R8)
        for (int i = 0; i < 16; i++)
            issue_op(3'(i % 7), 32'h0001_0000 + 32'(i * 13), 1'(i % 3 != 0), 1'(i % 4 != 1),
                     7'(100 + i), 1'(i % 2));
        idle();
        repeat (6) @(negedge clk);

        chk(q.size() == 0, "R2 drained", 32'(q.size()), 32'h0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule